// File: doc/BRIEF.md
# Ethernet Receive Destination-Address Filter

This block watches the byte stream of each received Ethernet frame and decides whether a downstream DMA engine should copy that frame to memory. The stream arrives one byte per cycle with a start-of-frame strobe on the first destination byte. The block gathers the six destination bytes and compares the 48-bit address against four programmable slots. It also recognises the broadcast address and applies a half-duplex rule: a frame is refused when its destination address arrives while the local transmitter is active.

Software programs the slots and three configuration bits through a simple register write port. A slot is switched on by writing its upper register and switched off by writing its lower register, so a half-written address can never match. The decision appears with a one-cycle valid pulse and is held on the accept output until the next frame starts. Bytes after the destination field, including the source address, play no part in the decision.

Top module: `eth_da_filter`

## Requirements
- R1: After reset, dec_valid and dec_accept are 0, all four slots are inactive and all configuration bits are 0, so a frame that would match a programmed address is rejected.
- R2: For a frame of at least six bytes, dec_valid pulses high for exactly one cycle, on the cycle after the sixth byte (counted from the byte carrying rx_sof) is sampled. dec_accept carries the decision in that same cycle.
- R3: The destination byte order is octet 0 first. Octet k sits in bits 8k+7..8k of the 48-bit address. The lower slot register holds octets 0..3 in wdata[31:0] (octet 0 in bits 7:0). The upper register holds octets 4..5 in wdata[15:0] (octet 4 in bits 7:0). Bits 31:16 of an upper write are ignored.
- R4: A slot becomes active when its upper register is written and inactive when its lower register is written.
- R5: A frame is rejected when its destination address equals no active slot and none of the broadcast or copy-all rules applies. This includes group addresses (bit 0 of octet 0 set) that are not all ones. An inactive slot never matches.
- R6: An all-ones destination is accepted when configuration bit 1 (no-broadcast) is 0 and rejected when that bit is 1, unless another rule accepts it.
- R7: When configuration bit 0 (copy-all) is 1, every frame is accepted, subject to R8.
- R8: If tx_hd_busy is high in any cycle in which one of the six destination bytes is sampled, the frame is rejected. This does not apply when configuration bit 2 (receive-while-transmit) is 1. tx_hd_busy outside those cycles has no effect.
- R9: Bytes after the sixth, including the source address, do not change the decision. dec_accept holds its value until the cycle after the next rx_sof byte, when it clears to 0.
- R10: If a frame ends (rx_eof with rx_valid) before its sixth byte, dec_valid pulses on the cycle after that last byte and dec_accept is 0.
- R11: Register addresses are as follows: slot n lower at 2n, slot n upper at 2n+1 (n = 0..3), configuration at 8. Writes to addresses 9..15 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A receive byte is present on rx_data |
| rx_sof | input | 1 | With rx_valid: this byte is destination octet 0 |
| rx_eof | input | 1 | With rx_valid: this byte is the last of the frame |
| rx_data | input | 8 | Receive byte |
| tx_hd_busy | input | 1 | Transmitter active in half-duplex mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| dec_valid | output | 1 | One-cycle pulse: decision available |
| dec_accept | output | 1 | 1 = copy frame to memory, held until next frame |

## Verification
A wrong slot-enable bit or a byte placed in the wrong lane of the collected address shows up as a wrong accept level on the decision pulse of the very next frame aimed at that slot. A byte counter that is off by one moves the valid pulse by one cycle, or makes a short frame produce two pulses or none. A sticky transmit flag that fails to clear at the start of a frame rejects the following clean frame. The bench models all of this per cycle and compares dec_valid and dec_accept on every clock, so any such fault is flagged in the cycle it reaches the ports.

// File: rtl/eth_da_pkg.sv
package eth_da_pkg;
  localparam int DA_BYTES = 6;
  localparam int DA_BITS  = DA_BYTES * 8;

  typedef logic [DA_BITS-1:0] mac_t;

  // bit 0: copy-all, bit 1: no-broadcast, bit 2: receive-while-transmit
  typedef struct packed {
    logic rx_in_tx;
    logic no_bcast;
    logic copy_all;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/eth_da_regs.sv
module eth_da_regs
  import eth_da_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 4,
  parameter int DW        = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [NUM_SLOTS-1:0][DA_BITS-1:0] slot_mac,
  output logic [NUM_SLOTS-1:0]         slot_act,
  output cfg_t                         cfg
);
  localparam int LO_W     = 32;
  localparam int HI_W     = DA_BITS - LO_W;
  localparam int CFG_ADDR = 2 * NUM_SLOTS;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [AW-1:0] LO_ADDR = AW'(2 * g);
    localparam logic [AW-1:0] HI_ADDR = AW'(2 * g + 1);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;
    logic            act_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q  <= '0;
        hi_q  <= '0;
        act_q <= 1'b0;
      end else if (we && addr == LO_ADDR) begin
        lo_q  <= wdata[LO_W-1:0];
        act_q <= 1'b0;
      end else if (we && addr == HI_ADDR) begin
        hi_q  <= wdata[HI_W-1:0];
        act_q <= 1'b1;
      end
    end

    assign slot_mac[g] = {hi_q, lo_q};
    assign slot_act[g] = act_q;

    // R4
    slot_on_chk: assert property (@(posedge clk) disable iff (rst)
      (we && addr == HI_ADDR) |=> slot_act[g]);
    // R4
    slot_off_chk: assert property (@(posedge clk) disable iff (rst)
      (we && addr == LO_ADDR) |=> !slot_act[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we && addr == AW'(CFG_ADDR)) begin
      cfg <= cfg_t'(wdata[CFG_W-1:0]);
    end
  end

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == AW'(CFG_ADDR)) |=> $stable(cfg));
endmodule

// File: rtl/eth_da_collect.sv
module eth_da_collect
  import eth_da_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_sof,
  input  logic       rx_eof,
  input  logic [7:0] rx_data,
  input  logic       tx_hd_busy,
  output logic       frame_start,
  output logic       da_done,
  output logic       short_end,
  output mac_t       da_word,
  output logic       tx_hit
);
  localparam int CW = $clog2(DA_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(DA_BYTES - 1);

  logic          collecting;
  logic [CW-1:0] cnt;
  mac_t          da_q;
  logic          tx_seen;
  logic          take;
  logic [CW-1:0] idx;

  assign frame_start = rx_valid && rx_sof;
  assign take        = rx_valid && (rx_sof || collecting);
  assign idx         = frame_start ? '0 : cnt;
  assign da_done     = take && (idx == LAST);
  assign short_end   = take && rx_eof && (idx != LAST);
  assign tx_hit      = take && ((frame_start ? 1'b0 : tx_seen) || tx_hd_busy);

  always_comb begin
    da_word = frame_start ? '0 : da_q;
    if (take) begin
      da_word[8*idx +: 8] = rx_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      collecting <= 1'b0;
      cnt        <= '0;
      da_q       <= '0;
      tx_seen    <= 1'b0;
    end else if (take) begin
      da_q    <= da_word;
      tx_seen <= tx_hit;
      cnt     <= idx + 1'b1;
      if (da_done || short_end) begin
        collecting <= 1'b0;
      end else begin
        collecting <= 1'b1;
      end
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    collecting |-> (cnt < CW'(DA_BYTES)));
  // R9
  stop_after_da_chk: assert property (@(posedge clk) disable iff (rst)
    da_done |=> !collecting);
endmodule

// File: rtl/eth_da_match.sv
module eth_da_match
  import eth_da_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  mac_t                              da,
  input  logic [NUM_SLOTS-1:0][DA_BITS-1:0] slot_mac,
  input  logic [NUM_SLOTS-1:0]              slot_act,
  input  cfg_t                              cfg,
  input  logic                              tx_hit,
  output logic                              accept
);
  logic [NUM_SLOTS-1:0] hit;
  logic                 is_bcast;
  logic                 addr_ok;
  logic                 duplex_ok;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign hit[g] = slot_act[g] && (slot_mac[g] == da);
  end

  assign is_bcast  = &da;
  assign addr_ok   = cfg.copy_all || (|hit) || (is_bcast && !cfg.no_bcast);
  assign duplex_ok = !tx_hit || cfg.rx_in_tx;
  assign accept    = addr_ok && duplex_ok;
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import eth_da_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int AW        = 4,
  parameter int DW        = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_valid,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic [7:0]    rx_data,
  input  logic          tx_hd_busy,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic          dec_valid,
  output logic          dec_accept
);
  logic [NUM_SLOTS-1:0][DA_BITS-1:0] slot_mac;
  logic [NUM_SLOTS-1:0]              slot_act;
  cfg_t cfg;
  logic frame_start, da_done, short_end, tx_hit, match_ok;
  mac_t da_word;

  eth_da_regs #(.NUM_SLOTS(NUM_SLOTS), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .slot_mac(slot_mac), .slot_act(slot_act), .cfg(cfg)
  );

  eth_da_collect u_collect (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .tx_hd_busy(tx_hd_busy),
    .frame_start(frame_start), .da_done(da_done), .short_end(short_end),
    .da_word(da_word), .tx_hit(tx_hit)
  );

  eth_da_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
    .da(da_word), .slot_mac(slot_mac), .slot_act(slot_act), .cfg(cfg),
    .tx_hit(tx_hit), .accept(match_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
    end else begin
      dec_valid <= da_done || short_end;
      if (da_done) begin
        dec_accept <= match_ok;
      end else if (short_end || frame_start) begin
        dec_accept <= 1'b0;
      end
    end
  end

  // R10
  short_reject_chk: assert property (@(posedge clk) disable iff (rst)
    short_end |=> (dec_valid && !dec_accept));
  // R8
  hd_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (da_done && tx_hit && !cfg.rx_in_tx) |=> (dec_valid && !dec_accept));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(da_done || short_end || frame_start) |=> $stable(dec_accept));
  // R2
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    !(da_done || short_end) |=> !dec_valid);
endmodule

// File: tb/eth_da_filter_test.sv
module eth_da_filter_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        rx_valid, rx_sof, rx_eof, tx_hd_busy, reg_we;
  logic [7:0]  rx_data;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic        dec_valid, dec_accept;

  int    tests = 0, fails = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // reference model state
  logic [31:0] m_lo [4];
  logic [15:0] m_hi [4];
  bit          m_act [4];
  logic [2:0]  m_cfg;
  bit          m_coll;
  int          m_cnt;
  logic [7:0]  m_da [6];
  bit          m_tx;
  bit          exp_valid, exp_acc;

  eth_da_filter uut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .tx_hd_busy(tx_hd_busy), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit model_accept();
    logic [47:0] d;
    bit hit = 0;
    for (int k = 0; k < 6; k++) d[8*k +: 8] = m_da[k];
    for (int s = 0; s < 4; s++)
      if (m_act[s] && {m_hi[s], m_lo[s]} == d) hit = 1;
    return !(m_tx && !m_cfg[2]) && (m_cfg[0] || hit || (d == '1 && !m_cfg[1]));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < 4; s++) begin m_lo[s] = 0; m_hi[s] = 0; m_act[s] = 0; end
      m_cfg = 0; m_coll = 0; m_cnt = 0; m_tx = 0;
      exp_valid = 0; exp_acc = 0;
    end else begin
      exp_valid = 0;
      if (rx_valid && (rx_sof || m_coll)) begin
        int idx;
        idx = rx_sof ? 0 : m_cnt;
        if (rx_sof) m_tx = 0;
        m_da[idx] = rx_data;
        if (tx_hd_busy) m_tx = 1;
        if (idx == 5) begin
          exp_valid = 1; exp_acc = model_accept(); m_coll = 0;
        end else if (rx_eof) begin
          exp_valid = 1; exp_acc = 0; m_coll = 0;
        end else begin
          if (rx_sof) exp_acc = 0;
          m_coll = 1; m_cnt = idx + 1;
        end
      end
      if (reg_we) begin
        if (reg_addr == 8) m_cfg = reg_wdata[2:0];
        else if (reg_addr < 8) begin
          if (reg_addr[0]) begin
            m_hi[reg_addr/2] = reg_wdata[15:0]; m_act[reg_addr/2] = 1;
          end else begin
            m_lo[reg_addr/2] = reg_wdata; m_act[reg_addr/2] = 0;
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(dec_valid == exp_valid, {cur_req, " valid"}, dec_valid, exp_valid);
      check(dec_accept == exp_acc, {cur_req, " accept"}, dec_accept, exp_acc);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  // da: octet k in bits 8k+7..8k; short_n > 0 gives a frame of that many bytes
  task automatic send(input logic [47:0] da, input int tx_at, input int short_n,
                      input string req);
    int n, pulses, pos;
    n = (short_n > 0) ? short_n : 14;
    pulses = 0; pos = -1;
    for (int i = 0; i <= n; i++) begin
      @(negedge clk);
      if (i > 0 && dec_valid) begin pulses++; pos = i - 1; end
      if (i < n) begin
        rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
        rx_data = (i < 6) ? da[8*i +: 8] : 8'(8'h30 + i);
        tx_hd_busy = (i == tx_at);
      end else begin
        rx_valid = 0; rx_sof = 0; rx_eof = 0; tx_hd_busy = 0;
      end
    end
    check(pulses == 1, {req, " pulse count"}, pulses, 1);
    check(pos == ((short_n > 0) ? short_n - 1 : 5), {req, " pulse cycle"}, pos,
          (short_n > 0) ? short_n - 1 : 5);
    repeat (2) @(negedge clk);
  endtask

  localparam logic [47:0] MAC_A = 48'hCBA9_8765_4321;
  localparam logic [47:0] MAC_B = 48'h0102_0304_0506;
  localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

  initial begin
    rst = 1; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
    tx_hd_busy = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    check(dec_valid == 0, "R1 valid in reset", dec_valid, 0);
    rst = 0;
    @(negedge clk);
    check(dec_accept == 0, "R1 accept after reset", dec_accept, 0);

    cur_req = "R1";
    send(MAC_A, -1, 0, "R1");
    check(dec_accept == 0, "R1 no active slot", dec_accept, 0);

    cur_req = "R3";
    wr(4'd0, 32'h8765_4321);
    wr(4'd1, 32'hFFFF_CBA9);
    send(MAC_A, -1, 0, "R3");
    check(dec_accept == 1, "R3 slot0 match", dec_accept, 1);
    repeat (5) @(negedge clk);
    check(dec_accept == 1, "R9 held after idle", dec_accept, 1);

    cur_req = "R5";
    send(MAC_A ^ 48'h0100_0000_0000, -1, 0, "R5");
    check(dec_accept == 0, "R5 one octet differs", dec_accept, 0);
    send(48'h0000_0000_0001, -1, 0, "R5");
    check(dec_accept == 0, "R5 group not in slot", dec_accept, 0);

    cur_req = "R4";
    wr(4'd0, 32'h8765_4321);
    send(MAC_A, -1, 0, "R4");
    check(dec_accept == 0, "R4 lower write deactivates", dec_accept, 0);
    wr(4'd1, 32'h0000_CBA9);
    send(MAC_A, -1, 0, "R4");
    check(dec_accept == 1, "R4 upper write activates", dec_accept, 1);

    cur_req = "R11";
    wr(4'd6, 32'h0304_0506);
    wr(4'd7, 32'h0000_0102);
    wr(4'd9, 32'h0000_0007);
    wr(4'd15, 32'h0000_0001);
    send(MAC_B, -1, 0, "R11");
    check(dec_accept == 1, "R11 slot3 match", dec_accept, 1);
    send(48'h0000_0000_0A00, -1, 0, "R11");
    check(dec_accept == 0, "R11 writes above 8 ignored", dec_accept, 0);

    cur_req = "R6";
    send(BCAST, -1, 0, "R6");
    check(dec_accept == 1, "R6 broadcast accepted", dec_accept, 1);
    wr(4'd8, 32'h2);
    send(BCAST, -1, 0, "R6");
    check(dec_accept == 0, "R6 broadcast blocked", dec_accept, 0);

    cur_req = "R7";
    wr(4'd8, 32'h1);
    send(48'h0000_0000_0A00, -1, 0, "R7");
    check(dec_accept == 1, "R7 copy-all", dec_accept, 1);
    send(48'h0000_0000_0A00, 3, 0, "R8");
    check(dec_accept == 0, "R8 copy-all still blocked by tx", dec_accept, 0);

    cur_req = "R8";
    wr(4'd8, 32'h0);
    send(MAC_A, 5, 0, "R8");
    check(dec_accept == 0, "R8 tx on last DA byte", dec_accept, 0);
    send(MAC_A, 0, 0, "R8");
    check(dec_accept == 0, "R8 tx on first DA byte", dec_accept, 0);
    send(MAC_A, 8, 0, "R8");
    check(dec_accept == 1, "R8 tx after DA ignored", dec_accept, 1);
    wr(4'd8, 32'h4);
    send(MAC_A, 2, 0, "R8");
    check(dec_accept == 1, "R8 receive-while-transmit", dec_accept, 1);

    cur_req = "R10";
    wr(4'd8, 32'h0);
    send(MAC_A, -1, 3, "R10");
    check(dec_accept == 0, "R10 short frame", dec_accept, 0);
    send(MAC_A, -1, 1, "R10");
    check(dec_accept == 0, "R10 one-byte frame", dec_accept, 0);

    cur_req = "R2";
    send(MAC_B, -1, 6, "R2");
    check(dec_accept == 1, "R2 exactly six bytes", dec_accept, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog %s: actual %0d expected %0d", cur_req, 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule